// File: doc/BRIEF.md
# PLL Operating Mode Controller

This block is the digital supervisor of a clock-synthesis loop. It steps the loop through five operating modes: initialisation, free-run, lock acquisition, locked and holdover. It moves between them on four signals: whether a valid reference input is selected, a loss-of-lock flag from the phase detector, a software force-hold control, and a history qualifier. The qualifier comes from an internal timer that measures how long the loop has been tracking a valid input. Holdover is only used when enough frequency history exists. Without it, the loop falls back to free-run.

The controller also chooses which loop-bandwidth set the analog loop should use: normal, fastlock or a dedicated holdover-exit set. When holdover is left, a ramp-bypass control decides between a frequency ramp and a selectable bandwidth. A live status bit reports holdover or free-run. A sticky copy of that bit feeds a maskable interrupt. Configuration arrives as plain input ports from a register block elsewhere.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While reset is held, mode reads 0 (initialisation) and hold_flag and irq read 0. Mode becomes 1 (free-run) on the INIT_CYC-th rising clock edge after reset is released.
- R2: From free-run (1), the block moves to lock acquisition (2) one edge after in_valid=1 with force_hold=0. From acquisition it moves to locked (3) one edge after lol=0. From locked it returns to acquisition one edge after lol=1.
- R3: In acquisition or locked with in_valid=0, the next mode is holdover (4) if hist_valid=1, and free-run (1) otherwise.
- R4: A tick occurs every TICK_DIV clock cycles, counted from reset release. The history count advances on each tick while mode is 2 or 3 and in_valid=1. hist_valid is 1 once the count reaches 2^hist_len_exp + 2^hist_dly_exp.
- R5: The history count is cleared on every entry into free-run, so hist_valid reads 0 there.
- R6: With force_hold=1 and mode not 0, the next mode is holdover if hist_valid=1 and free-run otherwise. The block stays there while force_hold remains 1, whatever in_valid is.
- R7: From holdover, in_valid=1 with force_hold=0 moves the block to acquisition. It reaches locked only through acquisition, once lol=0.
- R8: Outside a holdover exit, bw_sel is 1 (fastlock) when fastlock_en=1 and lol=1. Otherwise it is 0 (normal).
- R9: During acquisition entered from holdover with ramp_bypass=1, exit_bw_sel picks bw_sel: 00 gives 1 (fastlock), 01 gives 2 (holdover-exit), and 10 or 11 give 0 (normal).
- R10: During acquisition entered from holdover with ramp_bypass=0, ramp_active=1 and bw_sel=0. ramp_active is 0 at all other times.
- R11: hold_status is 1 exactly when mode is 1 or 4.
- R12: hold_flag is set on the edge after hold_status=1. A flag_clr pulse clears it only on an edge where hold_status=0.
- R13: irq equals hold_flag while hold_irq_mask=0 and is 0 while hold_irq_mask=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A valid reference input is selected |
| lol | input | 1 | Loss of lock from the loop |
| force_hold | input | 1 | Force holdover or free-run |
| fastlock_en | input | 1 | Enable fastlock bandwidth during loss of lock |
| ramp_bypass | input | 1 | 1: leave holdover with a chosen bandwidth; 0: by ramp |
| exit_bw_sel | input | 2 | Bandwidth choice on holdover exit (reset value in the register block: 01) |
| hist_len_exp | input | EXP_W | History window, power-of-two exponent in ticks |
| hist_dly_exp | input | EXP_W | History delay, power-of-two exponent in ticks |
| hold_irq_mask | input | 1 | Masks the holdover interrupt |
| flag_clr | input | 1 | Write-zero strobe for the sticky flag |
| mode | output | 3 | 0 init, 1 free-run, 2 acquire, 3 locked, 4 holdover |
| hold_status | output | 1 | Live holdover/free-run status |
| hold_flag | output | 1 | Sticky holdover/free-run flag |
| irq | output | 1 | Interrupt |
| bw_sel | output | 2 | 0 normal, 1 fastlock, 2 holdover-exit bandwidth set |
| ramp_active | output | 1 | Holdover exit by frequency ramp in progress |
| hist_valid | output | 1 | Frequency history is sufficient for holdover |

## Verification
The bench builds the block with INIT_CYC=4 and TICK_DIV=4, and drives history exponents of 2 and 1. The history threshold is then six ticks, about 24 cycles, so the bench can reach both outcomes of an input failure (holdover and free-run fallback) in a short run. It can also show that an early failure clears the count: a second locking episode that would pass the threshold only if the count had been kept still reads hist_valid=0. A second reset gives force-hold with no history, and every exit-bandwidth code is swept while the block is in acquisition after holdover.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

  typedef enum logic [2:0] {
    MODE_INIT     = 3'd0,
    MODE_FREERUN  = 3'd1,
    MODE_ACQUIRE  = 3'd2,
    MODE_LOCKED   = 3'd3,
    MODE_HOLDOVER = 3'd4
  } pll_mode_e;

  typedef enum logic [1:0] {
    BW_NORMAL   = 2'd0,
    BW_FAST     = 2'd1,
    BW_HOLDEXIT = 2'd2
  } bw_set_e;

  // Ticks of tracking needed before holdover is allowed.
  function automatic logic [31:0] hist_target(input logic [31:0] len_exp,
                                              input logic [31:0] dly_exp);
    return (32'd1 << len_exp) + (32'd1 << dly_exp);
  endfunction

  // Bandwidth used while leaving holdover without a ramp.
  function automatic bw_set_e exit_bw(input logic [1:0] sel);
    case (sel)
      2'b00:   return BW_FAST;
      2'b01:   return BW_HOLDEXIT;
      default: return BW_NORMAL;
    endcase
  endfunction

  function automatic logic is_hold_mode(input pll_mode_e m);
    return (m == MODE_FREERUN) || (m == MODE_HOLDOVER);
  endfunction

endpackage

// File: rtl/pll_hist_timer.sv
module pll_hist_timer
  import pll_mode_pkg::*;
#(
  parameter int TICK_DIV = 16,
  parameter int EXP_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             clear,
  input  logic [EXP_W-1:0] len_exp,
  input  logic [EXP_W-1:0] dly_exp,
  output logic             hist_valid
);
  localparam int PS_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = (1 << EXP_W) + 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICK_DIV - 1);

  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic [31:0]      target;

  assign tick       = (ps_q == PS_LAST);
  assign target     = hist_target(32'(len_exp), 32'(dly_exp));
  assign hist_valid = (32'(cnt_q) >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ps_q <= '0;
    else if (tick) ps_q <= '0;
    else           ps_q <= ps_q + 1'b1;
  end

  // Saturates at the threshold; cleared on free-run entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (clear)                            cnt_q <= '0;
    else if (tick && count_en && !hist_valid)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
#(
  parameter int INIT_CYC = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  logic      lol,
  input  logic      force_hold,
  input  logic      hist_valid,
  output pll_mode_e mode_q,
  output logic      exit_phase,
  output logic      enter_freerun
);
  localparam int IC_W = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;
  localparam logic [IC_W-1:0] IC_LAST = IC_W'(INIT_CYC - 1);

  pll_mode_e       mode_d;
  pll_mode_e       fallback;
  logic [IC_W-1:0] init_cnt_q;
  logic            input_lost;

  assign fallback   = hist_valid ? MODE_HOLDOVER : MODE_FREERUN;
  assign input_lost = force_hold || !in_valid;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_INIT:     if (init_cnt_q == IC_LAST) mode_d = MODE_FREERUN;
      MODE_FREERUN:  if (!input_lost) mode_d = MODE_ACQUIRE;
      MODE_ACQUIRE:  if (input_lost) mode_d = fallback;
                     else if (!lol) mode_d = MODE_LOCKED;
      MODE_LOCKED:   if (input_lost) mode_d = fallback;
                     else if (lol) mode_d = MODE_ACQUIRE;
      MODE_HOLDOVER: if (!input_lost) mode_d = MODE_ACQUIRE;
      default:       mode_d = MODE_FREERUN;
    endcase
  end

  assign enter_freerun = (mode_d == MODE_FREERUN) && (mode_q != MODE_FREERUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_INIT;
      init_cnt_q <= '0;
      exit_phase <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (mode_q == MODE_INIT) init_cnt_q <= init_cnt_q + 1'b1;
      if (mode_q == MODE_HOLDOVER && mode_d == MODE_ACQUIRE) exit_phase <= 1'b1;
      else if (mode_d != MODE_ACQUIRE)                       exit_phase <= 1'b0;
    end
  end

endmodule

// File: rtl/pll_bw_select.sv
module pll_bw_select
  import pll_mode_pkg::*;
(
  input  logic       exit_phase,
  input  logic       lol,
  input  logic       fastlock_en,
  input  logic       ramp_bypass,
  input  logic [1:0] exit_bw_sel,
  output bw_set_e    bw_sel,
  output logic       ramp_active
);
  assign ramp_active = exit_phase && !ramp_bypass;

  always_comb begin
    if (exit_phase && ramp_bypass) bw_sel = exit_bw(exit_bw_sel);
    else if (exit_phase)           bw_sel = BW_NORMAL;
    else if (fastlock_en && lol)   bw_sel = BW_FAST;
    else                           bw_sel = BW_NORMAL;
  end

endmodule

// File: rtl/pll_hold_status.sv
module pll_hold_status
  import pll_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pll_mode_e mode,
  input  logic      flag_clr,
  input  logic      irq_mask,
  output logic      hold_status,
  output logic      hold_flag,
  output logic      irq
);
  assign hold_status = is_hold_mode(mode);
  assign irq         = hold_flag && !irq_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold_flag <= 1'b0;
    else if (hold_status) hold_flag <= 1'b1;
    else if (flag_clr)    hold_flag <= 1'b0;
  end

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
#(
  parameter int INIT_CYC = 8,
  parameter int TICK_DIV = 16,
  parameter int EXP_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             lol,
  input  logic             force_hold,
  input  logic             fastlock_en,
  input  logic             ramp_bypass,
  input  logic [1:0]       exit_bw_sel,
  input  logic [EXP_W-1:0] hist_len_exp,
  input  logic [EXP_W-1:0] hist_dly_exp,
  input  logic             hold_irq_mask,
  input  logic             flag_clr,
  output logic [2:0]       mode,
  output logic             hold_status,
  output logic             hold_flag,
  output logic             irq,
  output logic [1:0]       bw_sel,
  output logic             ramp_active,
  output logic             hist_valid
);
  pll_mode_e mode_q;
  bw_set_e   bw_set;
  logic      exit_phase;
  logic      enter_freerun;
  logic      tracking;

  assign tracking = in_valid && (mode_q == MODE_ACQUIRE || mode_q == MODE_LOCKED);

  pll_hist_timer #(.TICK_DIV(TICK_DIV), .EXP_W(EXP_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .count_en(tracking), .clear(enter_freerun),
    .len_exp(hist_len_exp), .dly_exp(hist_dly_exp), .hist_valid(hist_valid)
  );

  pll_mode_fsm #(.INIT_CYC(INIT_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lol(lol),
    .force_hold(force_hold), .hist_valid(hist_valid), .mode_q(mode_q),
    .exit_phase(exit_phase), .enter_freerun(enter_freerun)
  );

  pll_bw_select u_bw (
    .exit_phase(exit_phase), .lol(lol), .fastlock_en(fastlock_en),
    .ramp_bypass(ramp_bypass), .exit_bw_sel(exit_bw_sel),
    .bw_sel(bw_set), .ramp_active(ramp_active)
  );

  pll_hold_status u_stat (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .flag_clr(flag_clr),
    .irq_mask(hold_irq_mask), .hold_status(hold_status),
    .hold_flag(hold_flag), .irq(irq)
  );

  assign mode   = mode_q;
  assign bw_sel = bw_set;

endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       in_valid,
  input logic       force_hold,
  input logic       hist_valid,
  input logic       hold_status,
  input logic       hold_flag,
  input logic       flag_clr,
  input logic       irq,
  input logic       hold_irq_mask,
  input logic       exit_phase,
  input logic       ramp_bypass,
  input logic [1:0] exit_bw_sel,
  input logic [1:0] bw_sel
);

  a_r3_fail_to_freerun: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd2 || mode == 3'd3) && !in_valid && !hist_valid) |=> (mode == 3'd1));

  a_r3_fail_to_holdover: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !in_valid && hist_valid) |=> (mode == 3'd4));

  a_r5_history_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && $past(mode) != 3'd1) |-> !hist_valid);

  a_r6_force_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hold && mode != 3'd0) |=> (mode == 3'd1 || mode == 3'd4));

  a_r9_exit_bw: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_phase && ramp_bypass && exit_bw_sel == 2'b01) |-> (bw_sel == 2'd2));

  a_r12_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hold_status |=> hold_flag);

  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_flag && !flag_clr) |=> hold_flag);

  a_r13_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    hold_irq_mask |-> !irq);

endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
  .force_hold(force_hold), .hist_valid(hist_valid), .hold_status(hold_status),
  .hold_flag(hold_flag), .flag_clr(flag_clr), .irq(irq),
  .hold_irq_mask(hold_irq_mask), .exit_phase(exit_phase),
  .ramp_bypass(ramp_bypass), .exit_bw_sel(exit_bw_sel), .bw_sel(bw_sel)
);

// File: tb/test_pll_mode_ctrl.sv
`timescale 1ns/1ps
module test_pll_mode_ctrl;
  localparam int INIT_CYC = 4;
  localparam int TICK_DIV = 4;
  localparam int EXP_W    = 4;
  localparam int LEN_E    = 2;
  localparam int DLY_E    = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, lol = 1, force_hold = 0, fastlock_en = 0, ramp_bypass = 0;
  logic [1:0] exit_bw_sel = 2'b01;
  logic [EXP_W-1:0] hist_len_exp = EXP_W'(LEN_E);
  logic [EXP_W-1:0] hist_dly_exp = EXP_W'(DLY_E);
  logic hold_irq_mask = 0, flag_clr = 0;
  logic [2:0] mode;
  logic hold_status, hold_flag, irq, ramp_active, hist_valid;
  logic [1:0] bw_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_mode, m_init, m_ps, m_hist, m_exit, m_flag;

  always #10 clk = ~clk;

  pll_mode_ctrl #(.INIT_CYC(INIT_CYC), .TICK_DIV(TICK_DIV), .EXP_W(EXP_W)) i_pll_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lol(lol), .force_hold(force_hold),
    .fastlock_en(fastlock_en), .ramp_bypass(ramp_bypass), .exit_bw_sel(exit_bw_sel),
    .hist_len_exp(hist_len_exp), .hist_dly_exp(hist_dly_exp),
    .hold_irq_mask(hold_irq_mask), .flag_clr(flag_clr), .mode(mode),
    .hold_status(hold_status), .hold_flag(hold_flag), .irq(irq), .bw_sel(bw_sel),
    .ramp_active(ramp_active), .hist_valid(hist_valid)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int need_ticks();
    return (1 << LEN_E) + (1 << DLY_E);
  endfunction

  function automatic int exp_bw();
    if (m_exit != 0 && ramp_bypass) begin
      if (exit_bw_sel == 2'b00) return 1;
      if (exit_bw_sel == 2'b01) return 2;
      return 0;
    end
    if (m_exit != 0) return 0;
    return (fastlock_en && lol) ? 1 : 0;
  endfunction

  task automatic model_reset();
    m_mode = 0; m_init = INIT_CYC; m_ps = 0; m_hist = 0; m_exit = 0; m_flag = 0;
  endtask

  task automatic model_edge();
    int nm;
    bit hv, tk, lost;
    hv = (m_hist >= need_ticks());
    tk = (m_ps == TICK_DIV - 1);
    lost = force_hold || !in_valid;
    nm = m_mode;
    if (m_mode == 0) begin
      if (m_init == 1) nm = 1;
    end else if (m_mode == 1 || m_mode == 4) begin
      if (!lost) nm = 2;
    end else if (lost) nm = hv ? 4 : 1;
    else if (m_mode == 2 && !lol) nm = 3;
    else if (m_mode == 3 && lol) nm = 2;
    if (nm == 1 && m_mode != 1) m_hist = 0;
    else if (tk && in_valid && (m_mode == 2 || m_mode == 3) && !hv) m_hist++;
    if (m_mode == 4 && nm == 2) m_exit = 1;
    else if (nm != 2) m_exit = 0;
    if (m_mode == 1 || m_mode == 4) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    if (m_mode == 0) m_init--;
    m_ps = (m_ps + 1) % TICK_DIV;
    m_mode = nm;
  endtask

  task automatic compare();
    chk("R2 mode", mode, m_mode);
    chk("R11 status", hold_status, (m_mode == 1 || m_mode == 4) ? 1 : 0);
    chk("R12 flag", hold_flag, m_flag);
    chk("R13 irq", irq, (m_flag != 0 && !hold_irq_mask) ? 1 : 0);
    chk("R4 hist_valid", hist_valid, (m_hist >= need_ticks()) ? 1 : 0);
    chk("R8 bw_sel", bw_sel, exp_bw());
    chk("R10 ramp", ramp_active, (m_exit != 0 && !ramp_bypass) ? 1 : 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset flag", hold_flag, 0);
    chk("R1 reset irq", irq, 0);
    rst_n = 1;
  endtask

  initial begin
    in_valid = 0; lol = 1;
    do_reset();
    run(3);
    chk("R1 still init", mode, 0);
    run(1);
    chk("R1 free-run", mode, 1);
    chk("R11 status in free-run", hold_status, 1);
    run(1);
    chk("R13 irq from flag", irq, 1);

    in_valid = 1; lol = 1; fastlock_en = 1;
    run(1);
    chk("R2 acquire", mode, 2);
    chk("R8 fastlock bw", bw_sel, 1);
    fastlock_en = 0;
    run(1);
    chk("R8 fastlock disabled", bw_sel, 0);
    fastlock_en = 1; lol = 0;
    run(1);
    chk("R2 locked", mode, 3);
    chk("R8 normal when locked", bw_sel, 0);
    run(14);
    in_valid = 0;
    run(1);
    chk("R3 no history to free-run", mode, 1);

    in_valid = 1;
    run(2);
    chk("R2 relocked", mode, 3);
    run(12);
    chk("R5 history restarted", hist_valid, 0);
    run(20);
    chk("R4 history valid", hist_valid, 1);
    in_valid = 0;
    run(1);
    chk("R3 holdover", mode, 4);
    flag_clr = 1;
    run(1);
    flag_clr = 0;
    chk("R12 clear ignored while live", hold_flag, 1);
    hold_irq_mask = 1;
    run(1);
    chk("R13 masked", irq, 0);
    hold_irq_mask = 0;

    ramp_bypass = 1; exit_bw_sel = 2'b01; in_valid = 1; lol = 1;
    run(1);
    chk("R7 exit to acquire", mode, 2);
    chk("R9 sel01 exit bw", bw_sel, 2);
    exit_bw_sel = 2'b00;
    run(1);
    chk("R9 sel00 fastlock", bw_sel, 1);
    exit_bw_sel = 2'b10;
    run(1);
    chk("R9 sel10 normal", bw_sel, 0);
    exit_bw_sel = 2'b11;
    run(1);
    chk("R9 sel11 normal", bw_sel, 0);
    lol = 0;
    run(1);
    chk("R7 locked after exit", mode, 3);
    flag_clr = 1;
    run(1);
    flag_clr = 0;
    chk("R12 flag cleared", hold_flag, 0);

    force_hold = 1;
    run(1);
    chk("R6 forced holdover", mode, 4);
    run(3);
    chk("R6 stays forced", mode, 4);
    ramp_bypass = 0; lol = 1; fastlock_en = 1; force_hold = 0;
    run(1);
    chk("R7 acquire after force", mode, 2);
    chk("R10 ramp active", ramp_active, 1);
    chk("R10 ramp bw normal", bw_sel, 0);
    lol = 0;
    run(1);
    chk("R7 locked", mode, 3);
    chk("R10 ramp done", ramp_active, 0);
    lol = 1;
    run(1);
    chk("R2 lock lost", mode, 2);
    chk("R8 fastlock on relock", bw_sel, 1);
    lol = 0;
    run(1);

    in_valid = 0; lol = 1;
    do_reset();
    run(4);
    chk("R1 free-run again", mode, 1);
    in_valid = 1;
    run(1);
    chk("R2 acquire again", mode, 2);
    force_hold = 1;
    run(1);
    chk("R6 forced free-run", mode, 1);
    run(2);
    chk("R6 free-run held", mode, 1);
    force_hold = 0;
    run(1);
    chk("R6 released", mode, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule